// File: doc/BRIEF.md
# TDM PRBS Error Monitor with Lock Detection

This block watches one received time-division stream of 256 timeslots per frame and checks a pseudo-random test pattern carried in a run of adjacent timeslots. A first-slot setting and a span setting select the run. Both settings are taken modulo 256, so a run may wrap from slot 255 to slot 0. Only bytes in that run are compared. The span has to match the number of timeslots into which the far-end generator writes the pattern, or the comparison is meaningless.

The local reference is self-synchronising on the polynomial x^15 + x^14 + 1. Each received bit is predicted from the received bits 15 and 14 positions earlier, so the checker takes up the incoming sequence without a seed. The block declares lock after a run of clean bytes. While lock holds, it accumulates mismatched bits in a saturating 16-bit counter. It drops lock when the error density gets too high.

A receive-enable input gates the whole block. A one-cycle clear input zeroes the counter. Timeslot demultiplexing and the host register access sit outside this block.

Top module: `tdm_prbs_monitor`

## Requirements
- R1: A byte is monitored only when byte_vld_i is 1, rx_en_i is 1, and ((ch_idx_i - start_ch_i) mod 256) < span_len_i, where span_len_i ranges from 0 to 256. With a span of 0 nothing is monitored. Bytes outside the run leave lock_o and err_cnt_o unchanged.
- R2: Bits of a monitored byte are taken MSB (bit 7) first. Each bit is compared with the XOR of the received bits 15 and 14 positions earlier in the monitored bit sequence. That history is all zero after reset or disable. A bit that differs is an error bit, and a byte with any error bit is an errored byte.
- R3: While unlocked, lock_o rises after the 16th consecutive error-free monitored byte. An errored byte restarts that run from zero.
- R4: While locked, monitored bytes are grouped into blocks of 64, counted from the byte after lock. When the 8th errored byte within one block arrives, lock_o falls. The errored-byte tally clears at each block end.
- R5: For each monitored byte that arrives while lock_o is 1, err_cnt_o increases by its number of error bits. No errors are added while lock_o is 0.
- R6: err_cnt_o saturates at 0xFFFF and holds there.
- R7: A one-cycle err_clr_i pulse sets err_cnt_o to 0 and does not change lock_o. Clear wins over an addition in the same cycle.
- R8: When rx_en_i is 0, or during reset, lock_o is 0, err_cnt_o is 0, and the bit history and lock tallies are cleared.
- R9: lock_o and err_cnt_o reflect a monitored byte on the first rising clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low clears and holds the block idle |
| start_ch_i | input | 8 | First timeslot of the monitored run |
| span_len_i | input | 9 | Number of monitored timeslots, 0 to 256 |
| ch_idx_i | input | 8 | Timeslot index of the byte on rx_data_i |
| byte_vld_i | input | 1 | rx_data_i holds a received byte this cycle |
| rx_data_i | input | 8 | Received byte |
| err_clr_i | input | 1 | Clear pulse for the error counter |
| lock_o | output | 1 | Pattern lock indication |
| err_cnt_o | output | 16 | Saturating bit-error count |

## Verification
Each result is registered once. lock_o and err_cnt_o therefore move on the same rising edge that samples a monitored byte, a clear pulse or a low enable. The bench changes inputs on the falling edge and compares outputs on the next falling edge, which is exactly one register stage after the stimulus. A bench-side reference model, written from the rules above, predicts lock and count after every byte. Directed checks then confirm specific boundaries: the wrapping run, the empty span, the lock loss, clear against add in the same cycle, and saturation.

// File: rtl/tdm_bert_pkg.sv
package tdm_bert_pkg;

  localparam int unsigned PRBS_ORDER = 15;
  localparam int unsigned PRBS_TAP   = 14;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_e;

  function automatic logic [5:0] ones32(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/tdm_bert_win.sv
module tdm_bert_win #(
  parameter int unsigned CH_W = 8
) (
  input  logic            rx_en_i,
  input  logic            byte_vld_i,
  input  logic [CH_W-1:0] ch_idx_i,
  input  logic [CH_W-1:0] start_ch_i,
  input  logic [CH_W:0]   span_len_i,
  output logic            hit_o
);
  logic [CH_W-1:0] off;

  // modulo distance from the first slot lets the run wrap
  assign off   = ch_idx_i - start_ch_i;
  assign hit_o = rx_en_i & byte_vld_i & ({1'b0, off} < span_len_i);
endmodule

// File: rtl/tdm_bert_prbs_chk.sv
module tdm_bert_prbs_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ORDER  = tdm_bert_pkg::PRBS_ORDER,
  parameter int unsigned TAP    = tdm_bert_pkg::PRBS_TAP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] err_o
);
  logic [ORDER-1:0] hist_q, hist_d;

  always_comb begin
    logic [ORDER-1:0] h;
    logic             pred;
    h     = hist_q;
    err_o = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      pred     = h[ORDER-1] ^ h[TAP-1];
      err_o[i] = data_i[i] ^ pred;
      h        = {h[ORDER-2:0], data_i[i]};  // self-sync: shift received bit
    end
    hist_d = h;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (flush_i) hist_q <= '0;
    else if (step_i)  hist_q <= hist_d;
  end
endmodule

// File: rtl/tdm_bert_lock.sv
module tdm_bert_lock #(
  parameter int unsigned GOOD_N = 16,
  parameter int unsigned BAD_N  = 8,
  parameter int unsigned BLK_N  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic step_i,
  input  logic byte_err_i,
  output logic lock_o
);
  import tdm_bert_pkg::*;

  localparam int unsigned GW = $clog2(GOOD_N);
  localparam int unsigned BW = $clog2(BAD_N + 1);
  localparam int unsigned KW = $clog2(BLK_N);

  lock_state_e     st_q;
  logic [GW-1:0]   good_q;
  logic [BW-1:0]   bad_q, bad_n;
  logic [KW-1:0]   blk_q;

  assign bad_n  = bad_q + {{(BW-1){1'b0}}, byte_err_i};
  assign lock_o = (st_q == ST_LOCKED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      bad_q  <= '0;
      blk_q  <= '0;
    end else if (flush_i) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      bad_q  <= '0;
      blk_q  <= '0;
    end else if (step_i) begin
      unique case (st_q)
        ST_HUNT: begin
          if (byte_err_i) begin
            good_q <= '0;
          end else if (good_q == GW'(GOOD_N - 1)) begin
            st_q   <= ST_LOCKED;
            good_q <= '0;
            bad_q  <= '0;
            blk_q  <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (bad_n == BW'(BAD_N)) begin
            st_q   <= ST_HUNT;
            good_q <= '0;
            bad_q  <= '0;
            blk_q  <= '0;
          end else if (blk_q == KW'(BLK_N - 1)) begin
            bad_q <= '0;
            blk_q <= '0;
          end else begin
            bad_q <= bad_n;
            blk_q <= blk_q + 1'b1;
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/tdm_bert_errcnt.sv
module tdm_bert_errcnt #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ADD_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [ADD_W-1:0] add_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + (CNT_W+1)'(add_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (flush_i | clr_i) cnt_o <= '0;
    else if (add_en_i)        cnt_o <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/tdm_prbs_monitor.sv
module tdm_prbs_monitor #(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned GOOD_N = 16,
  parameter int unsigned BAD_N  = 8,
  parameter int unsigned BLK_N  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic [CH_W-1:0]   start_ch_i,
  input  logic [CH_W:0]     span_len_i,
  input  logic [CH_W-1:0]   ch_idx_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              err_clr_i,
  output logic              lock_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  localparam int unsigned ADD_W = 6;

  logic              mon_step;
  logic              flush;
  logic [DATA_W-1:0] err_bits;
  logic [ADD_W-1:0]  n_err;

  assign flush = ~rx_en_i;
  assign n_err = tdm_bert_pkg::ones32(32'(err_bits));

  tdm_bert_win #(.CH_W(CH_W)) u_win (
    .rx_en_i    (rx_en_i),
    .byte_vld_i (byte_vld_i),
    .ch_idx_i   (ch_idx_i),
    .start_ch_i (start_ch_i),
    .span_len_i (span_len_i),
    .hit_o      (mon_step)
  );

  tdm_bert_prbs_chk #(.DATA_W(DATA_W)) u_chk_prbs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .step_i  (mon_step),
    .data_i  (rx_data_i),
    .err_o   (err_bits)
  );

  tdm_bert_lock #(.GOOD_N(GOOD_N), .BAD_N(BAD_N), .BLK_N(BLK_N)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .step_i     (mon_step),
    .byte_err_i (|err_bits),
    .lock_o     (lock_o)
  );

  // count uses lock state prior to this byte
  tdm_bert_errcnt #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .clr_i    (err_clr_i),
    .add_en_i (mon_step & lock_o),
    .add_i    (n_err),
    .cnt_o    (err_cnt_o)
  );
endmodule

// File: rtl/tdm_prbs_monitor_chk.sv
module tdm_prbs_monitor_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic             err_clr_i,
  input logic             mon_step_i,
  input logic             lock_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  assert_no_count_unlocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && !err_clr_i && !lock_o) |=> $stable(err_cnt_o));

  assert_idle_no_change_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && !err_clr_i && !mon_step_i) |=> ($stable(err_cnt_o) && $stable(lock_o)));

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && err_clr_i) |=> (err_cnt_o == '0 && $stable(lock_o)));

  assert_disable_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!lock_o && err_cnt_o == '0));

  assert_hold_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && !err_clr_i && err_cnt_o == '1) |=> (err_cnt_o == '1));

  assert_step_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && !err_clr_i) |=> (err_cnt_o >= $past(err_cnt_o) &&
                                 (err_cnt_o - $past(err_cnt_o)) <= CNT_W'(DATA_W)));

  assert_lock_on_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(mon_step_i));
endmodule

bind tdm_prbs_monitor tdm_prbs_monitor_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_mon_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en_i    (rx_en_i),
  .err_clr_i  (err_clr_i),
  .mon_step_i (mon_step),
  .lock_o     (lock_o),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/tdm_prbs_monitor_bench.sv
module tdm_prbs_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       rx_en_i = 1;
  logic [7:0] start_ch_i = 0;
  logic [8:0] span_len_i = 9'd256;
  logic [7:0] ch_idx_i = 0;
  logic       byte_vld_i = 0;
  logic [7:0] rx_data_i = 0;
  logic       err_clr_i = 0;
  logic       lock_o;
  logic [15:0] err_cnt_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [14:0] m_hist = '0;
  bit          m_lock = 0;
  int          m_good = 0, m_bad = 0, m_blk = 0, m_cnt = 0;
  logic [14:0] gen = 15'h0001;
  logic [7:0]  ch_run = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tdm_prbs_monitor u_tdm_prbs_monitor (
    .clk_i, .rst_ni, .rx_en_i, .start_ch_i, .span_len_i, .ch_idx_i,
    .byte_vld_i, .rx_data_i, .err_clr_i, .lock_o, .err_cnt_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_prbs();
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      b = gen[14] ^ gen[13];
      d[i] = b;
      gen = {gen[13:0], b};
    end
    return d;
  endfunction

  task automatic m_reset();
    m_hist = '0; m_lock = 0; m_good = 0; m_bad = 0; m_blk = 0; m_cnt = 0;
  endtask

  // R2..R6 model of one monitored byte
  task automatic m_byte(input logic [7:0] d);
    int e;
    bit was_lock;
    logic p;
    e = 0;
    for (int i = 7; i >= 0; i--) begin
      p = m_hist[14] ^ m_hist[13];
      if (d[i] != p) e++;
      m_hist = {m_hist[13:0], d[i]};
    end
    was_lock = m_lock;
    if (!m_lock) begin
      if (e != 0) m_good = 0;
      else if (m_good == 15) begin m_lock = 1; m_good = 0; m_bad = 0; m_blk = 0; end
      else m_good++;
    end else begin
      if (e != 0 && m_bad + 1 == 8) begin m_lock = 0; m_good = 0; m_bad = 0; m_blk = 0; end
      else if (m_blk == 63) begin m_bad = 0; m_blk = 0; end
      else begin m_bad += (e != 0); m_blk++; end
    end
    if (was_lock) begin
      m_cnt += e;
      if (m_cnt > 65535) m_cnt = 65535;
    end
  endtask

  task automatic put(input logic [7:0] ch, input logic [7:0] d, input bit clr);
    logic [7:0] off;
    ch_idx_i = ch; rx_data_i = d; byte_vld_i = 1; err_clr_i = clr;
    @(posedge clk_i);
    off = ch - start_ch_i;
    if (rx_en_i && ({1'b0, off} < span_len_i)) m_byte(d);
    if (clr) m_cnt = 0;
    @(negedge clk_i);
    byte_vld_i = 0; err_clr_i = 0;
    check(lock_o == m_lock, "R9 lock after byte", lock_o, m_lock);
    check(err_cnt_o == m_cnt[15:0], "R9 count after byte", err_cnt_o, m_cnt);
  endtask

  task automatic put_clean(input int n);
    for (int i = 0; i < n; i++) begin
      put(ch_run, next_prbs(), 0);
      ch_run++;
    end
  endtask

  task automatic disable_cycle();
    rx_en_i = 0;
    @(posedge clk_i);
    m_reset();
    @(negedge clk_i);
    check(lock_o == 0, "R8 lock cleared by disable", lock_o, 0);
    check(err_cnt_o == 0, "R8 count cleared by disable", err_cnt_o, 0);
    put(8'd3, 8'hFF, 0);
    check(lock_o == 0 && err_cnt_o == 0, "R8 byte ignored while disabled", err_cnt_o, 0);
    rx_en_i = 1;
  endtask

  task automatic t_reset();
    check(lock_o == 0, "R8 reset lock", lock_o, 0);
    check(err_cnt_o == 0, "R8 reset count", err_cnt_o, 0);
  endtask

  task automatic t_acquire();
    start_ch_i = 0; span_len_i = 9'd256;
    put_clean(40);
    check(lock_o == 1, "R3 lock after clean run", lock_o, 1);
    check(err_cnt_o == 0, "R5 no count before lock", err_cnt_o, 0);
    // errored byte resets run: flip bit, lose lock needs 8 so lock stays
    disable_cycle();
    put_clean(4);
    put(ch_run, next_prbs() ^ 8'h10, 0); ch_run++;
    put_clean(4);
    check(lock_o == m_lock, "R3 run restart after error", lock_o, m_lock);
    put_clean(30);
    check(lock_o == 1, "R3 relock", lock_o, 1);
  endtask

  task automatic t_single_flip();
    int base;
    base = err_cnt_o;
    put(ch_run, next_prbs() ^ 8'h80, 0); ch_run++;
    put_clean(2);
    check(err_cnt_o - base == 3, "R2 one flipped bit gives three errors", err_cnt_o - base, 3);
    check(lock_o == 1, "R4 lock held after few errors", lock_o, 1);
  endtask

  task automatic t_clear();
    check(err_cnt_o != 0, "R7 nonzero before clear", err_cnt_o, 1);
    put(ch_run, next_prbs(), 1); ch_run++;
    check(err_cnt_o == 0, "R7 clear zeroes count", err_cnt_o, 0);
    check(lock_o == 1, "R7 clear keeps lock", lock_o, 1);
    put(ch_run, next_prbs() ^ 8'hFF, 1); ch_run++;
    check(err_cnt_o == 0, "R7 clear wins over add", err_cnt_o, 0);
    put_clean(3);
  endtask

  task automatic t_window();
    int snap;
    disable_cycle();
    start_ch_i = 8'd250; span_len_i = 9'd10;
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 256; c++) begin
        logic [7:0] off;
        off = 8'(c) - start_ch_i;
        if (off < 10) put(8'(c), next_prbs(), 0);
        else put(8'(c), 8'hA5 ^ 8'(c), 0);
      end
    check(lock_o == 1, "R1 wrapping run locks", lock_o, 1);
    check(err_cnt_o == 0, "R1 outside bytes add nothing", err_cnt_o, 0);
    snap = err_cnt_o;
    for (int c = 4; c < 250; c++) put(8'(c), 8'h00, 0);
    check(err_cnt_o == snap && lock_o == 1, "R1 garbage outside run ignored", err_cnt_o, snap);
    disable_cycle();
    span_len_i = 9'd0;
    for (int i = 0; i < 40; i++) put(8'(i), next_prbs(), 0);
    check(lock_o == 0, "R1 empty span never locks", lock_o, 0);
    start_ch_i = 0; span_len_i = 9'd256;
  endtask

  task automatic t_loss();
    int snap;
    put_clean(20);
    check(lock_o == 1, "R4 locked before burst", lock_o, 1);
    for (int i = 0; i < 8; i++) begin put(ch_run, ~next_prbs(), 0); ch_run++; end
    check(lock_o == 0, "R4 lock lost after 8 errored bytes", lock_o, 0);
    snap = err_cnt_o;
    check(snap != 0, "R5 count retained after loss", snap, 1);
    put(ch_run, ~next_prbs(), 0); ch_run++;
    check(err_cnt_o == snap, "R5 no count while unlocked", err_cnt_o, snap);
    put_clean(24);
    check(lock_o == 1, "R3 reacquire after loss", lock_o, 1);
  endtask

  task automatic t_saturate();
    while (m_cnt < 65535) begin
      for (int j = 0; j < 64; j++) begin
        logic [7:0] d;
        d = next_prbs();
        put(ch_run, (j < 6) ? ~d : d, 0); ch_run++;
      end
    end
    check(err_cnt_o == 16'hFFFF, "R6 saturated", err_cnt_o, 16'hFFFF);
    check(lock_o == 1, "R4 seven errored bytes per block keep lock", lock_o, 1);
    for (int j = 0; j < 64; j++) begin
      logic [7:0] d;
      d = next_prbs();
      put(ch_run, (j < 6) ? ~d : d, 0); ch_run++;
    end
    check(err_cnt_o == 16'hFFFF, "R6 holds at max", err_cnt_o, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_acquire();
    t_single_flip();
    t_clear();
    t_window();
    t_loss();
    t_saturate();
    disable_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule